// File: doc/BRIEF.md
# Clock Output Enable and Shutdown Control

This block decides, for each of four clock outputs, whether it runs, floats or is held in a fixed parked level. The inputs are one shared external control pin and a set of configuration bits. The pin is asynchronous, so it is brought into the core clock domain through a two-flop synchroniser before anything decodes it. A polarity bit chooses which pin level counts as asserted. A function bit makes the pin either a global shutdown or a per-output enable gate.

Each output has three bits. An enable bit turns the output on, and while it is clear the output floats. A pin-control bit lets the pin gate the output. A complement-inversion bit sets whether the complement leg follows the true leg or is its inverse. Global shutdown overrides every other bit: it parks all outputs and drops the oscillator-loop enable. The state of each output is held in a register that may change only at an edge where that output's divided clock is low. This way no shortened pulse reaches the output.

The block reports each output as a two-bit state code and drives the gated true and complement clock legs. The divided clocks are synchronous to the core clock.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: While reset is held, every output state code is 1 (floating), both legs of every output are 0, and `osc_loop_en` is 0.
- R2: When no global shutdown is in force, an output whose enable bit is 0 has state code 1 (floating) and both legs at 0, whatever its pin-control bit and the pin level.
- R3: An enabled output whose pin-control bit is 0 has state code 0 (running) at either pin level, provided no global shutdown is in force.
- R4: In enable mode (`cfg_sd_mode`=0), an enabled output whose pin-control bit is 1 has state code 2 (parked) while the pin is at its disabling level. When parked, the true leg is 1 and the complement leg is 0.
- R5: With `cfg_pol`=0 a low pin is the asserting level, and with `cfg_pol`=1 a high pin is. The asserting level enables outputs in enable mode and requests shutdown in shutdown mode. The other level is the disabling level.
- R6: In shutdown mode (`cfg_sd_mode`=1) with the pin asserted, every output, enabled or not, takes state code 2 and `osc_loop_en` is 0. Otherwise `osc_loop_en` is 1.
- R7: In shutdown mode with the pin not asserted, pin-control bits have no effect. Enabled outputs have state code 0 and disabled outputs have state code 1.
- R8: A running output drives its true leg equal to its divided clock. Its complement leg equals the divided clock when `cfg_cmp_inv` is 0 and the inverse when it is 1.
- R9: A pin change shows up in the state codes and in `osc_loop_en` after the third rising clock edge that follows it, and not after the second.
- R10: An output's state code changes only at a rising edge where that output's `div_clk` bit is low. While the bit stays high, the code is held even when its target changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_oe_pin | input | 1 | Shared shutdown / enable pin, asynchronous |
| cfg_pol | input | 1 | Pin polarity: 0 asserted low, 1 asserted high |
| cfg_sd_mode | input | 1 | Pin function: 1 global shutdown, 0 output enable |
| cfg_out_en | input | NOUT | Per-output enable bits |
| cfg_pin_ctl | input | NOUT | Per-output pin-gating bits |
| cfg_cmp_inv | input | NOUT | Per-output complement inversion |
| div_clk | input | NOUT | Divided clock of each output |
| out_state | output | 2*NOUT | State code per output: 0 running, 1 floating, 2 parked |
| out_true | output | NOUT | True leg of each output |
| out_comp | output | NOUT | Complement leg of each output |
| osc_loop_en | output | 1 | Enable for the oscillator loop |

## Verification
Global shutdown and the low-clock gating rule can act in the same cycle. The shutdown request drops `osc_loop_en` at once, but an output whose divided clock is high must keep its old state until the clock falls. The bench provokes this by asserting the pin in shutdown mode while one output's divided clock is held high. It then checks that the loop enable falls after the third edge, that the other outputs park, and that the held output stays running with its true leg high. It checks again after the clock is released low, when that output parks on the next edge.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;
    localparam int OST_W = 2;
    typedef enum logic [OST_W-1:0] {
        OST_ACTIVE = 2'd0,
        OST_TRI    = 2'd1,
        OST_PARK   = 2'd2
    } ost_e;
endpackage

// File: rtl/clkout_gate_sync.sv
module clkout_gate_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clkout_gate_decode.sv
module clkout_gate_decode
    import clkout_gate_pkg::*;
#(
    parameter int NOUT = 4
) (
    input  logic                  pin_s,
    input  logic                  pol,
    input  logic                  sd_mode,
    input  logic [NOUT-1:0]       out_en,
    input  logic [NOUT-1:0]       pin_ctl,
    output logic [OST_W*NOUT-1:0] target,
    output logic                  loop_en
);
    logic pin_asserted;
    logic shutdown;

    always_comb begin
        pin_asserted = pol ? pin_s : ~pin_s;
        shutdown     = sd_mode & pin_asserted;
        loop_en      = ~shutdown;
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        ost_e tgt;
        always_comb begin
            if (shutdown)
                tgt = OST_PARK;
            else if (!out_en[g])
                tgt = OST_TRI;
            else if (!sd_mode && pin_ctl[g] && !pin_asserted)
                tgt = OST_PARK;
            else
                tgt = OST_ACTIVE;
        end
        assign target[OST_W*g +: OST_W] = tgt;
    end
endmodule

// File: rtl/clkout_gate_lane.sv
module clkout_gate_lane
    import clkout_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OST_W-1:0] target,
    input  logic             div_clk,
    input  logic             cmp_inv,
    output logic [OST_W-1:0] state,
    output logic             leg_t,
    output logic             leg_c
);
    ost_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!div_clk) st_d = ost_e'(target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OST_TRI;
        else        st_q <= st_d;
    end

    always_comb begin
        leg_t = 1'b0;
        leg_c = 1'b0;
        case (st_q)
            OST_ACTIVE: begin
                leg_t = div_clk;
                leg_c = div_clk ^ cmp_inv;
            end
            OST_PARK: begin
                leg_t = 1'b1;
                leg_c = 1'b0;
            end
            default: begin
                leg_t = 1'b0;
                leg_c = 1'b0;
            end
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
    import clkout_gate_pkg::*;
#(
    parameter int NOUT        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sd_oe_pin,
    input  logic                  cfg_pol,
    input  logic                  cfg_sd_mode,
    input  logic [NOUT-1:0]       cfg_out_en,
    input  logic [NOUT-1:0]       cfg_pin_ctl,
    input  logic [NOUT-1:0]       cfg_cmp_inv,
    input  logic [NOUT-1:0]       div_clk,
    output logic [OST_W*NOUT-1:0] out_state,
    output logic [NOUT-1:0]       out_true,
    output logic [NOUT-1:0]       out_comp,
    output logic                  osc_loop_en
);
    typedef struct packed {
        logic loop_en;
    } ctl_t;

    logic                  pin_s;
    logic [OST_W*NOUT-1:0] target;
    logic                  loop_en_next;
    ctl_t                  ctl_d, ctl_q;

    clkout_gate_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sd_oe_pin),
        .q     (pin_s)
    );

    clkout_gate_decode #(
        .NOUT (NOUT)
    ) decode_i (
        .pin_s   (pin_s),
        .pol     (cfg_pol),
        .sd_mode (cfg_sd_mode),
        .out_en  (cfg_out_en),
        .pin_ctl (cfg_pin_ctl),
        .target  (target),
        .loop_en (loop_en_next)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.loop_en = loop_en_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign osc_loop_en = ctl_q.loop_en;

    for (genvar g = 0; g < NOUT; g++) begin : g_lane
        clkout_gate_lane lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .target  (target[OST_W*g +: OST_W]),
            .div_clk (div_clk[g]),
            .cmp_inv (cfg_cmp_inv[g]),
            .state   (out_state[OST_W*g +: OST_W]),
            .leg_t   (out_true[g]),
            .leg_c   (out_comp[g])
        );
    end
endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk #(
    parameter int NOUT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_sd_mode,
    input logic [NOUT-1:0]   div_clk,
    input logic [2*NOUT-1:0] out_state,
    input logic [NOUT-1:0]   out_true,
    input logic [NOUT-1:0]   out_comp,
    input logic              osc_loop_en
);
    // R6: in enable mode the loop enable is always on
    a_r6_loop_on_in_oe_mode: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_sd_mode)) |-> osc_loop_en);

    for (genvar g = 0; g < NOUT; g++) begin : g_chk
        // R10: a high divided clock freezes the lane state
        a_r10_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
            div_clk[g] |=> $stable(out_state[2*g +: 2]));
        // R4: a parked lane shows true high, complement low
        a_r4_park_legs: assert property (@(posedge clk) disable iff (!rst_n)
            (out_state[2*g +: 2] == 2'd2) |-> (out_true[g] && !out_comp[g]));
        // R2: a floating lane drives both legs low
        a_r2_tri_legs: assert property (@(posedge clk) disable iff (!rst_n)
            (out_state[2*g +: 2] == 2'd1) |-> (!out_true[g] && !out_comp[g]));
    end
endmodule

bind clkout_gate_ctrl clkout_gate_chk #(.NOUT(NOUT)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sd_mode (cfg_sd_mode),
    .div_clk     (div_clk),
    .out_state   (out_state),
    .out_true    (out_true),
    .out_comp    (out_comp),
    .osc_loop_en (osc_loop_en)
);

// File: tb/clkout_gate_ctrl_tb_top.sv
module clkout_gate_ctrl_tb_top;
    localparam int NOUT = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pin = 1'b0;
    logic            pol = 1'b0;
    logic            sdm = 1'b0;
    logic [NOUT-1:0] oen = '0;
    logic [NOUT-1:0] pctl = '0;
    logic [NOUT-1:0] cinv = '0;
    logic [NOUT-1:0] dclk = '0;
    logic [2*NOUT-1:0] st;
    logic [NOUT-1:0]   lt, lc;
    logic              loop_en;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    clkout_gate_ctrl #(.NOUT(NOUT)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sd_oe_pin   (pin),
        .cfg_pol     (pol),
        .cfg_sd_mode (sdm),
        .cfg_out_en  (oen),
        .cfg_pin_ctl (pctl),
        .cfg_cmp_inv (cinv),
        .div_clk     (dclk),
        .out_state   (st),
        .out_true    (lt),
        .out_comp    (lc),
        .osc_loop_en (loop_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 state", st, 8'h55);
        chk("R1 true", lt, 4'h0);
        chk("R1 comp", lc, 4'h0);
        chk("R1 loop", loop_en, 1'b0);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_disabled();
        pol = 0; sdm = 0; oen = 4'h0; pctl = 4'hF; pin = 1'b1;
        settle();
        chk("R2 state", st, 8'h55);
        chk("R2 legs", {lt, lc}, 8'h00);
        chk("R6 loop on in enable mode", loop_en, 1'b1);
    endtask

    task automatic t_no_pinctl();
        oen = 4'hF; pctl = 4'h0; pin = 1'b1;
        settle();
        chk("R3 pin high", st, 8'h00);
        pin = 1'b0;
        settle();
        chk("R3 pin low", st, 8'h00);
    endtask

    task automatic t_park();
        oen = 4'hF; pctl = 4'b0101; pol = 0; pin = 1'b1;
        settle();
        chk("R4 state", st, 8'h22);
        chk("R4 true", lt, 4'b0101);
        chk("R4 comp", lc, 4'b0000);
    endtask

    task automatic t_polarity();
        pol = 1; pin = 1'b1;
        settle();
        chk("R5 high enables", st, 8'h00);
        pin = 1'b0;
        settle();
        chk("R5 low disables", st, 8'h22);
        oen = 4'b0011; pctl = 4'hF;
        settle();
        chk("R2 float beats pin control", st, 8'h5A);
    endtask

    task automatic t_shutdown();
        sdm = 1; pol = 0; oen = 4'b0011; pctl = 4'hF; pin = 1'b0;
        settle();
        chk("R6 all parked", st, 8'hAA);
        chk("R6 loop off", loop_en, 1'b0);
        chk("R6 true legs", lt, 4'hF);
        pin = 1'b1;
        settle();
        chk("R7 pin control ignored", st, 8'h50);
        chk("R6 loop on", loop_en, 1'b1);
        pol = 1;
        settle();
        chk("R5 high requests shutdown", st, 8'hAA);
    endtask

    task automatic t_latency();
        sdm = 0; pol = 0; oen = 4'hF; pctl = 4'hF; pin = 1'b0;
        settle();
        chk("R9 start running", st, 8'h00);
        pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 unchanged after 2 edges", st, 8'h00);
        @(negedge clk);
        chk("R9 parked after 3 edges", st, 8'hAA);
        sdm = 1; pol = 0; pin = 1'b1;
        settle();
        chk("R9 loop on before", loop_en, 1'b1);
        pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 loop unchanged after 2 edges", loop_en, 1'b1);
        @(negedge clk);
        chk("R9 loop off after 3 edges", loop_en, 1'b0);
    endtask

    task automatic t_complement();
        sdm = 0; oen = 4'hF; pctl = 4'h0; cinv = 4'b1010; dclk = 4'h0;
        settle();
        chk("R8 true low", lt, 4'h0);
        chk("R8 comp low clock", lc, 4'b1010);
        dclk = 4'hF;
        @(negedge clk);
        chk("R8 true high", lt, 4'hF);
        chk("R8 comp high clock", lc, 4'b0101);
        chk("R10 state held", st, 8'h00);
        dclk = 4'h0; cinv = 4'h0;
        settle();
    endtask

    task automatic t_hold_vs_shutdown();
        sdm = 1; pol = 0; oen = 4'hF; pctl = 4'h0; pin = 1'b1; dclk = 4'h0;
        settle();
        chk("R10 start running", st, 8'h00);
        dclk = 4'b0001;
        pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 loop drops with lane held", loop_en, 1'b0);
        settle();
        chk("R10 lane 0 held running", st, 8'hA8);
        chk("R10 lane 0 true follows clock", lt, 4'hF);
        dclk = 4'h0;
        @(negedge clk);
        chk("R10 lane 0 parks after clock low", st, 8'hAA);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_no_pinctl();
        t_park();
        t_polarity();
        t_shutdown();
        t_latency();
        t_complement();
        t_hold_vs_shutdown();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end
endmodule